// File: doc/BRIEF.md
# Row-Interleaved Byte Memory with Per-Row Wear Counting

This block is a synchronous byte-wide memory of 8K locations. Its single access port carries one read or one write per clock. Internally the address splits into three fields. The upper bits pick one of eight blocks, the middle bits pick one of four column slots, and the lowest bits pick the row. Because the row comes from the least significant bits, a linear walk through memory visits a different row on every step. Rows stay inside their block, so the block field together with the row field names one of 2048 rows.

Every access, whether read or write, stresses the whole addressed row, not only the byte it touches. The block therefore keeps one saturating wear counter per row and adds one to it on each access. A side port can ask for any row's count without adding to it. A sticky warning output goes high once any row's count reaches a configurable endurance limit, which defaults to 1E8. It also holds the block and row of the first row that got there. Software and test logic use this to steer frequently changing data away from rows that hold long-lived data.

Top module: `wear_mem`

## Requirements
- R1: The access address decodes as block = addr[12:10], column = addr[9:8] and row = addr[7:0]. Every one of the 8192 addresses holds an independent byte, including addresses that share a row and differ only in column.
- R2: A read request returns its byte on `rd_data` with `rd_valid` high in the clock after the request. `rd_valid` is low in any cycle that does not follow a read request.
- R3: A write request stores `req_wdata` at the clock edge where it is presented. Any later read of that address returns the stored byte.
- R4: Each accepted read or write adds exactly one to the counter of the row named by {block, row}, whatever the column field holds.
- R5: An access leaves the counters of all other rows unchanged.
- R6: A row counter that holds its maximum value 2^CNT_W-1 stays at that value on further accesses instead of wrapping.
- R7: A query for {block,row} returns that row's count on `qry_count` with `qry_ready` high one clock later. The query itself does not change the count. When an access to the same row falls in the query's cycle, the returned value is the count before that access.
- R8: `warn_flag` rises in the clock after the access that brings a row's count to `WARN_THRESH`. At that moment `warn_block` and `warn_row` take that row's block and row. Later rows reaching the limit change none of these outputs.
- R9: Reset clears every row counter and drops `warn_flag`, `rd_valid` and `qry_ready`.
- R10: Reading 256 consecutive addresses from a block boundary touches each row of that block exactly once. Sweeping all 1024 addresses of a block touches each of its rows exactly four times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BLK_W+COL_W+ROW_W (13) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| rd_data | output | DATA_W (8) | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data present |
| qry_valid | input | 1 | Counter query request |
| qry_block | input | BLK_W (3) | Block of the queried row |
| qry_row | input | ROW_W (8) | Row of the queried row |
| qry_count | output | CNT_W (27) | Queried row's count |
| qry_ready | output | 1 | Query result present |
| warn_flag | output | 1 | Sticky endurance-limit warning |
| warn_block | output | BLK_W (3) | Block of first row at the limit |
| warn_row | output | ROW_W (8) | Row of first row at the limit |

## Verification
The counter query and a normal access can land in the same clock. Both may name the same row, and then the counter is both read and incremented at once. The bench provokes this by presenting a read of a row together with a query of that row in one cycle. It expects the returned value to be the count before the access. A follow-up query must then show the count one higher. Two repeated queries with no access between them must return equal values. This separates a query that reports the old value from one that sees the new value or adds to the count itself.

// File: rtl/wear_mem_pkg.sv
package wear_mem_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10
   } mem_op_e;

endpackage

// File: rtl/wm_addr_decode.sv
module wm_addr_decode
   import wear_mem_pkg::*;
#(
   parameter int BLK_W = 3,
   parameter int COL_W = 2,
   parameter int ROW_W = 8,
   localparam int ADDR_W = BLK_W + COL_W + ROW_W,
   localparam int RIDX_W = BLK_W + ROW_W
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output mem_op_e           op,
   output logic [COL_W-1:0]  col,
   output logic [RIDX_W-1:0] row_idx
);

   logic [BLK_W-1:0] blk;
   logic [ROW_W-1:0] row;

   // low bits pick the row so linear walks rotate across rows
   assign row = req_addr[ROW_W-1:0];
   assign col = req_addr[ROW_W +: COL_W];
   assign blk = req_addr[ROW_W+COL_W +: BLK_W];
   assign row_idx = {blk, row};

   always_comb begin
      if (!req_valid)     op = OP_IDLE;
      else if (req_write) op = OP_WRITE;
      else                op = OP_READ;
   end

endmodule

// File: rtl/wm_row_array.sv
module wm_row_array
   import wear_mem_pkg::*;
#(
   parameter int RIDX_W = 11,
   parameter int COL_W  = 2,
   parameter int DATA_W = 8,
   localparam int COLS  = 1 << COL_W,
   localparam int ROWS  = 1 << RIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mem_op_e           op,
   input  logic [RIDX_W-1:0] row_idx,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [COLS*DATA_W-1:0] lane_bus;
   logic [COL_W-1:0]       col_q;

   // one storage lane per column slot; a read fetches the whole row
   for (genvar g = 0; g < COLS; g++) begin : g_lane
      logic [DATA_W-1:0] lane_mem [ROWS];
      logic [DATA_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (op == OP_WRITE && col == COL_W'(g))
            lane_mem[row_idx] <= wdata;
         if (op == OP_READ)
            lane_q <= lane_mem[row_idx];
      end

      assign lane_bus[g*DATA_W +: DATA_W] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         col_q    <= '0;
      end else begin
         rd_valid <= (op == OP_READ);
         if (op == OP_READ) col_q <= col;
      end
   end

   assign rd_data = lane_bus[col_q*DATA_W +: DATA_W];

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ) |=> rd_valid);                               // R2
   AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_READ) |=> !rd_valid);                              // R2

endmodule

// File: rtl/wm_wear_bank.sv
module wm_wear_bank #(
   parameter int          RIDX_W      = 11,
   parameter int          CNT_W       = 27,
   parameter int unsigned WARN_THRESH = 100_000_000,
   localparam int         ROWS        = 1 << RIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [RIDX_W-1:0] acc_idx,
   input  logic              qry_valid,
   input  logic [RIDX_W-1:0] qry_idx,
   output logic [CNT_W-1:0]  qry_count,
   output logic              qry_ready,
   output logic              warn_flag,
   output logic [RIDX_W-1:0] warn_idx
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WARN_THRESH);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("wm_wear_bank: CNT_W must lie in 1..32");
   end
   if (WARN_THRESH < 1 || longint'(WARN_THRESH) > ((longint'(1) << CNT_W) - 1)) begin : g_bad_thresh
      $error("wm_wear_bank: WARN_THRESH must fit in CNT_W and be nonzero");
   end

   logic [CNT_W-1:0] cnt_mem [ROWS];
   logic [CNT_W-1:0] cnt_cur;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_cur = cnt_mem[acc_idx];
   assign cnt_inc = (cnt_cur == CNT_MAX) ? CNT_MAX : cnt_cur + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ROWS; i++) cnt_mem[i] <= '0;
      end else if (acc_valid) begin
         cnt_mem[acc_idx] <= cnt_inc;
      end
   end

   // query samples the stored value, so a same-cycle access is not seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qry_ready <= 1'b0;
         qry_count <= '0;
      end else begin
         qry_ready <= qry_valid;
         if (qry_valid) qry_count <= cnt_mem[qry_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_flag <= 1'b0;
         warn_idx  <= '0;
      end else if (acc_valid && !warn_flag && cnt_inc >= CNT_LIM) begin
         warn_flag <= 1'b1;
         warn_idx  <= acc_idx;
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && cnt_cur != CNT_MAX) |=> cnt_mem[$past(acc_idx)] == $past(cnt_cur) + 1'b1); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && cnt_cur == CNT_MAX) |=> cnt_mem[$past(acc_idx)] == CNT_MAX);            // R6
   AST_QRY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      qry_valid |=> qry_ready);                                                             // R7
   AST_QRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_valid |=> !qry_ready);                                                           // R7
   AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      warn_flag |=> warn_flag && $stable(warn_idx));                                        // R8

endmodule

// File: rtl/wear_mem.sv
module wear_mem
   import wear_mem_pkg::*;
#(
   parameter int          BLK_W       = 3,
   parameter int          COL_W       = 2,
   parameter int          ROW_W       = 8,
   parameter int          DATA_W      = 8,
   parameter int          CNT_W       = 27,
   parameter int unsigned WARN_THRESH = 100_000_000,
   localparam int         ADDR_W      = BLK_W + COL_W + ROW_W,
   localparam int         RIDX_W      = BLK_W + ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              qry_valid,
   input  logic [BLK_W-1:0]  qry_block,
   input  logic [ROW_W-1:0]  qry_row,
   output logic [CNT_W-1:0]  qry_count,
   output logic              qry_ready,
   output logic              warn_flag,
   output logic [BLK_W-1:0]  warn_block,
   output logic [ROW_W-1:0]  warn_row
);

   if (BLK_W < 1 || COL_W < 0 || ROW_W < 1 || DATA_W < 1) begin : g_bad_geom
      $error("wear_mem: address and data widths must be positive");
   end

   mem_op_e           op;
   logic [COL_W-1:0]  col;
   logic [RIDX_W-1:0] row_idx;
   logic [RIDX_W-1:0] warn_idx;

   wm_addr_decode #(
      .BLK_W (BLK_W),
      .COL_W (COL_W),
      .ROW_W (ROW_W)
   ) decode_i (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .op        (op),
      .col       (col),
      .row_idx   (row_idx)
   );

   wm_row_array #(
      .RIDX_W (RIDX_W),
      .COL_W  (COL_W),
      .DATA_W (DATA_W)
   ) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .row_idx  (row_idx),
      .col      (col),
      .wdata    (req_wdata),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   wm_wear_bank #(
      .RIDX_W      (RIDX_W),
      .CNT_W       (CNT_W),
      .WARN_THRESH (WARN_THRESH)
   ) wear_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (op != OP_IDLE),
      .acc_idx   (row_idx),
      .qry_valid (qry_valid),
      .qry_idx   ({qry_block, qry_row}),
      .qry_count (qry_count),
      .qry_ready (qry_ready),
      .warn_flag (warn_flag),
      .warn_idx  (warn_idx)
   );

   assign warn_block = warn_idx[RIDX_W-1 -: BLK_W];
   assign warn_row   = warn_idx[ROW_W-1:0];

   AST_WARN_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (!warn_flag && !req_valid) |=> !warn_flag);                 // R8

endmodule

// File: tb/wear_mem_tb_top.sv
`timescale 1ns/1ps
module wear_mem_tb_top;

   localparam int CW = 5;
   localparam int TH = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        qry_valid = 1'b0;
   logic [2:0]  qry_block = '0;
   logic [7:0]  qry_row = '0;
   logic [CW-1:0] qry_count;
   logic        qry_ready, warn_flag;
   logic [2:0]  warn_block;
   logic [7:0]  warn_row;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wear_mem #(.CNT_W(CW), .WARN_THRESH(TH)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .qry_valid(qry_valid), .qry_block(qry_block), .qry_row(qry_row),
      .qry_count(qry_count), .qry_ready(qry_ready), .warn_flag(warn_flag),
      .warn_block(warn_block), .warn_row(warn_row));

   // address, write byte
   localparam logic [20:0] VEC [8] = '{
      {13'h0005, 8'hA1}, {13'h0105, 8'hB2}, {13'h0205, 8'hC3}, {13'h0305, 8'hD4},
      {13'h0405, 8'h5E}, {13'h1FFF, 8'h6F}, {13'h0000, 8'h70}, {13'h1C00, 8'h81}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic qry(input logic [2:0] b, input logic [7:0] r, output logic [31:0] c);
      @(negedge clk);
      qry_valid = 1'b1; qry_block = b; qry_row = r;
      @(negedge clk);
      qry_valid = 1'b0;
      check("R7 qry_ready", 32'(qry_ready), 32'd1);
      c = 32'(qry_count);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 rd_valid in reset", 32'(rd_valid), 0);
      check("R9 qry_ready in reset", 32'(qry_ready), 0);
      check("R9 warn_flag in reset", 32'(warn_flag), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [31:0] c;
      apply_reset();
      qry(3'd0, 8'd5, c); check("R9 counter cleared", c, 0);

      // table walk: write every entry, then read every entry back
      foreach (VEC[i]) begin
         acc(1'b1, VEC[i][20:8], VEC[i][7:0]);
         check("R2 no rd_valid after write", 32'(rd_valid), 0);
      end
      foreach (VEC[i]) begin
         acc(1'b0, VEC[i][20:8], 8'h00);
         check("R2 rd_valid", 32'(rd_valid), 1);
         check("R1 R3 read data", 32'(rd_data), 32'(VEC[i][7:0]));
      end

      qry(3'd0, 8'd5, c);   check("R4 shared row counts all columns", c, 8);
      qry(3'd1, 8'd5, c);   check("R4 block 1 row 5", c, 2);
      qry(3'd7, 8'd255, c); check("R4 block 7 row 255", c, 2);
      qry(3'd0, 8'd6, c);   check("R5 untouched row", c, 0);

      // R10 sweeps over block 2
      for (int a = 13'h0800; a < 13'h0900; a++) acc(1'b0, 13'(a), 8'h00);
      qry(3'd2, 8'd0, c);   check("R10 256 sweep row 0", c, 1);
      qry(3'd2, 8'd128, c); check("R10 256 sweep row 128", c, 1);
      qry(3'd2, 8'd255, c); check("R10 256 sweep row 255", c, 1);
      qry(3'd3, 8'd0, c);   check("R5 neighbour block", c, 0);
      for (int a = 13'h0900; a < 13'h0C00; a++) acc(1'b0, 13'(a), 8'h00);
      qry(3'd2, 8'd0, c);   check("R10 full sweep row 0", c, 4);
      qry(3'd2, 8'd77, c);  check("R10 full sweep row 77", c, 4);
      check("R8 no warning yet", 32'(warn_flag), 0);

      // R7 query and access to same row in one cycle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0005;
      qry_valid = 1'b1; qry_block = 3'd0; qry_row = 8'd5;
      @(negedge clk);
      req_valid = 1'b0; qry_valid = 1'b0;
      check("R7 same-cycle returns old count", 32'(qry_count), 8);
      check("R3 read during query", 32'(rd_data), 32'h A1);
      qry(3'd0, 8'd5, c); check("R7 count after same-cycle access", c, 9);
      qry(3'd0, 8'd5, c); check("R7 query does not increment", c, 9);

      // R8 threshold crossing
      repeat (10) acc(1'b0, 13'h0205, 8'h00);
      check("R8 below limit", 32'(warn_flag), 0);
      acc(1'b1, 13'h0305, 8'hD4);
      check("R8 flag at limit", 32'(warn_flag), 1);
      check("R8 warn_block", 32'(warn_block), 0);
      check("R8 warn_row", 32'(warn_row), 5);

      // R6 saturation at 31
      repeat (11) acc(1'b0, 13'h0105, 8'h00);
      qry(3'd0, 8'd5, c); check("R6 reaches max", c, 31);
      repeat (3) acc(1'b0, 13'h0005, 8'h00);
      qry(3'd0, 8'd5, c); check("R6 no wrap", c, 31);

      // R8 a second row reaching the limit changes nothing
      repeat (20) acc(1'b0, 13'h0C09, 8'h00);
      qry(3'd3, 8'd9, c); check("R4 second row count", c, 20);
      check("R8 sticky flag", 32'(warn_flag), 1);
      check("R8 first block kept", 32'(warn_block), 0);
      check("R8 first row kept", 32'(warn_row), 5);

      apply_reset();
      check("R9 flag low after reset", 32'(warn_flag), 0);
      qry(3'd0, 8'd5, c); check("R9 counter cleared again", c, 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule